// File: doc/BRIEF.md
# Host/Processor Handle Messaging Unit

This block lets a host and an embedded I/O processor pass 32-bit request handles between each other. The host reaches it through a simple 32-bit register port. That port has one read strobe and one write strobe, and it is addressed by a word offset, which is the byte offset divided by four. The processor side has three parts. It can pop requests that the host has posted. It can push completed handles back toward the host. It can seed a list of free handles that the host then allocates from.

Three queues carry the handles, and each has the same parametric depth. The free list feeds host allocations. The inbound post queue carries host requests to the processor. The outbound post queue carries completions to the host. The two queue ports act differently on read and on write. Reading the inbound port allocates a free handle and writing it posts a request. Reading the outbound port collects a completion and writing it gives a handle back to the free list. A handle with any of its top four bits set refers to host memory, so it is never put on the free list.

Alongside the queues, the block has two message registers in each direction and one inbound doorbell. Each direction also has an interrupt status register and an interrupt mask. The host interrupt is built from the outbound side and the processor interrupt from the inbound side.

Top module: `hostq_msgunit`

## Requirements
- R1: After reset, every queue is empty, all status, mask, message and doorbell registers read 0, and both interrupts are low.
- R2: A host read at byte offset 0x40 (word 16) returns the oldest free-list handle and removes it. When the free list is empty the read returns 0xFFFFFFFF and nothing changes.
- R3: A host write at 0x40 appends the value to the inbound post queue. The processor sees handles in order on p_idata while p_ivalid is high, and p_ipop removes the head. A write to a full queue is dropped and sets inbound status bit 3 (error).
- R4: A host write at 0x44 (word 17) with bits 31:28 all zero appends the value to the free list. A value with any of bits 31:28 set is discarded and leaves the free list unchanged.
- R5: A host read at 0x44 returns the oldest outbound handle and removes it. When the outbound queue is empty it returns 0xFFFFFFFF.
- R6: p_fpush seeds p_fdata into the free list. If a host return and a seed arrive in the same cycle, both are stored, with the host value first.
- R7: A host write at 0x10 or 0x14 stores inbound message 0 or 1. The stored value appears on p_imsg0 or p_imsg1, command codes included, and the write sets inbound status bit 0 or bit 1.
- R8: p_omsg_wr[k] stores p_omsg_data in outbound message k and sets outbound status bit k. The host reads message 0 at 0x18 and message 1 at 0x1C, and host writes to those offsets have no effect.
- R9: A host write at 0x20 ORs its data into the doorbell, and a nonzero write also sets inbound status bit 2. p_dbclr clears doorbell bits. p_oraise[0] sets outbound bit 2 and p_oraise[1] sets outbound bit 4.
- R10: Writing 1s at 0x24 (inbound) or 0x30 (outbound), or driving p_iclr, clears status bits. A set in the same cycle wins over a clear. Inbound bit 4 and outbound bit 3 are not stored: each is high exactly while its post queue is non-empty, and a clear does not affect them.
- R11: host_irq is the OR of the outbound status bits whose mask bit at 0x34 is 0. p_irq is the same for the inbound bits, with the mask at 0x28. Masks are 5 bits wide.
- R12: A processor push to a full outbound queue is dropped and sets inbound bit 3. So is any handle the free list cannot take.
- R13: Read data appears on h_rdata one cycle after h_rd, and h_rvalid is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_woff | input | 6 | Host word offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered |
| h_rvalid | output | 1 | Read data valid |
| host_irq | output | 1 | Host interrupt |
| p_ipop | input | 1 | Processor pops inbound post queue |
| p_ivalid | output | 1 | Inbound post queue not empty |
| p_idata | output | 32 | Inbound post queue head |
| p_opush | input | 1 | Processor pushes a completion |
| p_odata | input | 32 | Completion handle |
| p_fpush | input | 1 | Processor seeds free list |
| p_fdata | input | 32 | Seeded handle |
| p_imsg0 | output | 32 | Inbound message 0 |
| p_imsg1 | output | 32 | Inbound message 1 |
| p_omsg_wr | input | 2 | Outbound message write enables |
| p_omsg_data | input | 32 | Outbound message value |
| p_dbell | output | 32 | Doorbell bits |
| p_dbclr | input | 32 | Doorbell bit clear |
| p_istat | output | 5 | Inbound status view |
| p_iclr | input | 4 | Processor clear of inbound bits 3:0 |
| p_oraise | input | 2 | Raise outbound doorbell/PCI bits |
| p_irq | output | 1 | Processor interrupt |

## Verification
Each queue has a read pointer, a write pointer and a count, and these can drift apart. When they do, the host reads or the processor sees a handle in the wrong order, a repeated handle, or a stale one. It can also show as 0xFFFFFFFF while the queue still holds entries, or the reverse, on the very next pop after the fault. A bad count also shows within one cycle on the level status bits and on host_irq. A status register with bad set or clear priority shows on the next status read or as an interrupt that fails to rise or fall. The bench compares every pop and status read against a queue model, so such a fault is caught at the first access that touches it.

// File: rtl/hostq_msgunit.sv
`timescale 1ns/1ps
module hostq_msgunit #(
  parameter int DEPTH = 256,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_wr,
  input  logic        h_rd,
  input  logic [5:0]  h_woff,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  output logic        h_rvalid,
  output logic        host_irq,
  input  logic        p_ipop,
  output logic        p_ivalid,
  output logic [31:0] p_idata,
  input  logic        p_opush,
  input  logic [31:0] p_odata,
  input  logic        p_fpush,
  input  logic [31:0] p_fdata,
  output logic [31:0] p_imsg0,
  output logic [31:0] p_imsg1,
  input  logic [1:0]  p_omsg_wr,
  input  logic [31:0] p_omsg_data,
  output logic [31:0] p_dbell,
  input  logic [31:0] p_dbclr,
  output logic [4:0]  p_istat,
  input  logic [3:0]  p_iclr,
  input  logic [1:0]  p_oraise,
  output logic        p_irq
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [31:0] fl_mem [DEPTH];
  logic [31:0] ip_mem [DEPTH];
  logic [31:0] op_mem [DEPTH];
  logic [PW-1:0] fl_rp, fl_wp, ip_rp, ip_wp, op_rp, op_wp;
  logic [CW-1:0] fl_cnt, ip_cnt, op_cnt;
  logic [31:0] omsg0, omsg1;
  logic [3:0]  ist, ost;
  logic [4:0]  imask, omask;

  wire wr_iq = h_wr && h_woff == 6'd16;
  wire rd_iq = h_rd && h_woff == 6'd16;
  wire wr_oq = h_wr && h_woff == 6'd17;
  wire rd_oq = h_rd && h_woff == 6'd17;

  wire [CW-1:0] fl_room = FULL - fl_cnt;
  wire host_ret = wr_oq && h_wdata[31:28] == 4'd0;
  wire acc_h    = host_ret && fl_room != '0;
  wire acc_p    = p_fpush && (fl_room > CW'(acc_h));
  wire fl_pop   = rd_iq && fl_cnt != '0;
  wire fl_drop  = (host_ret && !acc_h) || (p_fpush && !acc_p);

  wire ip_push  = wr_iq && ip_cnt != FULL;
  wire ip_pop   = p_ipop && ip_cnt != '0;
  wire op_push  = p_opush && op_cnt != FULL;
  wire op_pop   = rd_oq && op_cnt != '0;
  wire err_set  = fl_drop || (wr_iq && !ip_push) || (p_opush && !op_push);

  wire [3:0] iset = {err_set, h_wr && h_woff == 6'd8 && h_wdata != 32'd0,
                     h_wr && h_woff == 6'd5, h_wr && h_woff == 6'd4};
  wire [3:0] iclr = p_iclr | ((h_wr && h_woff == 6'd9) ? h_wdata[3:0] : 4'd0);
  wire [3:0] oset = {p_oraise[1], p_oraise[0], p_omsg_wr};
  wire [3:0] oclr = (h_wr && h_woff == 6'd12) ? {h_wdata[4], h_wdata[2:0]} : 4'd0;

  wire [4:0] ostat = {ost[3], op_cnt != '0, ost[2:0]};
  assign p_istat  = {ip_cnt != '0, ist};
  assign host_irq = |(ostat & ~omask);
  assign p_irq    = |(p_istat & ~imask);
  assign p_ivalid = ip_cnt != '0;
  assign p_idata  = ip_mem[ip_rp];

  always_ff @(posedge clk) begin
    if (acc_h) fl_mem[fl_wp] <= h_wdata;
    if (acc_p) fl_mem[fl_wp + PW'(acc_h)] <= p_fdata;
    if (ip_push) ip_mem[ip_wp] <= h_wdata;
    if (op_push) op_mem[op_wp] <= p_odata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_rp <= '0; fl_wp <= '0; fl_cnt <= '0;
      ip_rp <= '0; ip_wp <= '0; ip_cnt <= '0;
      op_rp <= '0; op_wp <= '0; op_cnt <= '0;
    end else begin
      fl_wp  <= fl_wp + PW'(acc_h) + PW'(acc_p);
      fl_rp  <= fl_rp + PW'(fl_pop);
      fl_cnt <= fl_cnt + CW'(acc_h) + CW'(acc_p) - CW'(fl_pop);
      ip_wp  <= ip_wp + PW'(ip_push);
      ip_rp  <= ip_rp + PW'(ip_pop);
      ip_cnt <= ip_cnt + CW'(ip_push) - CW'(ip_pop);
      op_wp  <= op_wp + PW'(op_push);
      op_rp  <= op_rp + PW'(op_pop);
      op_cnt <= op_cnt + CW'(op_push) - CW'(op_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_imsg0 <= '0; p_imsg1 <= '0; omsg0 <= '0; omsg1 <= '0;
      p_dbell <= '0; ist <= '0; ost <= '0; imask <= '0; omask <= '0;
    end else begin
      if (h_wr && h_woff == 6'd4) p_imsg0 <= h_wdata;
      if (h_wr && h_woff == 6'd5) p_imsg1 <= h_wdata;
      if (h_wr && h_woff == 6'd10) imask <= h_wdata[4:0];
      if (h_wr && h_woff == 6'd13) omask <= h_wdata[4:0];
      if (p_omsg_wr[0]) omsg0 <= p_omsg_data;
      if (p_omsg_wr[1]) omsg1 <= p_omsg_data;
      p_dbell <= (p_dbell & ~p_dbclr) | ((h_wr && h_woff == 6'd8) ? h_wdata : 32'd0);
      ist <= (ist & ~iclr) | iset;
      ost <= (ost & ~oclr) | oset;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rdata  <= '0;
      h_rvalid <= 1'b0;
    end else begin
      h_rvalid <= h_rd;
      if (h_rd) begin
        case (h_woff)
          6'd4:    h_rdata <= p_imsg0;
          6'd5:    h_rdata <= p_imsg1;
          6'd6:    h_rdata <= omsg0;
          6'd7:    h_rdata <= omsg1;
          6'd8:    h_rdata <= p_dbell;
          6'd9:    h_rdata <= {27'd0, p_istat};
          6'd10:   h_rdata <= {27'd0, imask};
          6'd12:   h_rdata <= {27'd0, ostat};
          6'd13:   h_rdata <= {27'd0, omask};
          6'd16:   h_rdata <= fl_cnt != '0 ? fl_mem[fl_rp] : 32'hFFFF_FFFF;
          6'd17:   h_rdata <= op_cnt != '0 ? op_mem[op_rp] : 32'hFFFF_FFFF;
          default: h_rdata <= 32'd0;
        endcase
      end
    end
  end
endmodule

// File: rtl/hostq_msgunit_chk.sv
`timescale 1ns/1ps
module hostq_msgunit_chk #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_wr,
  input logic          h_rd,
  input logic [5:0]    h_woff,
  input logic [31:0]   h_wdata,
  input logic [31:0]   h_rdata,
  input logic          h_rvalid,
  input logic          host_irq,
  input logic          p_fpush,
  input logic          p_opush,
  input logic [1:0]    p_omsg_wr,
  input logic [31:0]   p_omsg_data,
  input logic [4:0]    p_istat,
  input logic [CW-1:0] fl_cnt,
  input logic [CW-1:0] ip_cnt,
  input logic [CW-1:0] op_cnt,
  input logic [31:0]   omsg0,
  input logic [4:0]    omask
);
  p_rvalid_next_r13: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd |=> h_rvalid);

  p_empty_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_woff == 6'd16 && fl_cnt == '0) |=> h_rdata == 32'hFFFF_FFFF);

  p_empty_collect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_woff == 6'd17 && op_cnt == '0) |=> h_rdata == 32'hFFFF_FFFF);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_woff == 6'd16 && ip_cnt == CW'(DEPTH)) |=> (p_istat[3] && ip_cnt == CW'(DEPTH)));

  p_host_handle_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && !h_rd && h_woff == 6'd17 && h_wdata[31:28] != 4'd0 && !p_fpush) |=> $stable(fl_cnt));

  p_omsg_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    p_omsg_wr[0] |=> omsg0 == $past(p_omsg_data));

  p_pending_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cnt != '0 && !omask[3]) |-> host_irq);

  p_outq_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (p_opush && op_cnt == CW'(DEPTH)) |=> (p_istat[3] && op_cnt != '0));
endmodule

bind hostq_msgunit hostq_msgunit_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_rd(h_rd), .h_woff(h_woff),
  .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid), .host_irq(host_irq),
  .p_fpush(p_fpush), .p_opush(p_opush), .p_omsg_wr(p_omsg_wr),
  .p_omsg_data(p_omsg_data), .p_istat(p_istat), .fl_cnt(fl_cnt),
  .ip_cnt(ip_cnt), .op_cnt(op_cnt), .omsg0(omsg0), .omask(omask)
);

// File: tb/sim_hostq_msgunit.sv
`timescale 1ns/1ps
module sim_hostq_msgunit;
  localparam int D = 8;
  logic clk = 0, rst_n = 0;
  logic h_wr = 0, h_rd = 0;
  logic [5:0] h_woff = 0;
  logic [31:0] h_wdata = 0, h_rdata;
  logic h_rvalid, host_irq;
  logic p_ipop = 0, p_ivalid;
  logic [31:0] p_idata;
  logic p_opush = 0, p_fpush = 0;
  logic [31:0] p_odata = 0, p_fdata = 0;
  logic [31:0] p_imsg0, p_imsg1, p_dbell;
  logic [1:0] p_omsg_wr = 0, p_oraise = 0;
  logic [31:0] p_omsg_data = 0, p_dbclr = 0;
  logic [4:0] p_istat;
  logic [3:0] p_iclr = 0;
  logic p_irq;

  always #2.5 clk = ~clk;

  hostq_msgunit #(.DEPTH(D)) u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] fl[$], ip[$], op[$];
  logic [3:0] m_ist = 0, m_ost = 0;
  logic [4:0] m_omask = 0, m_imask = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_ist();
    return {ip.size() != 0, m_ist};
  endfunction
  function automatic logic [4:0] exp_ost();
    return {m_ost[3], op.size() != 0, m_ost[2:0]};
  endfunction

  task automatic hwr(input logic [5:0] o, input logic [31:0] d);
    h_wr = 1; h_woff = o; h_wdata = d;
    @(posedge clk); @(negedge clk);
    h_wr = 0;
  endtask

  task automatic hrd(input logic [5:0] o, output logic [31:0] d);
    h_rd = 1; h_woff = o;
    @(posedge clk); @(negedge clk);
    h_rd = 0;
    d = h_rdata;
    chk("R13 rvalid", {31'd0, h_rvalid}, 32'd1);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    p_ipop = 0; p_opush = 0; p_fpush = 0; p_omsg_wr = 0; p_oraise = 0;
    p_dbclr = 0; p_iclr = 0;
  endtask

  task automatic m_post(input logic [31:0] v);
    if (ip.size() < D) ip.push_back(v); else m_ist[3] = 1;
    hwr(6'd16, v);
  endtask
  task automatic m_ret(input logic [31:0] v);
    if (v[31:28] == 0) begin
      if (fl.size() < D) fl.push_back(v); else m_ist[3] = 1;
    end
    hwr(6'd17, v);
  endtask
  task automatic m_seed(input logic [31:0] v);
    if (fl.size() < D) fl.push_back(v); else m_ist[3] = 1;
    p_fpush = 1; p_fdata = v; tick();
  endtask
  task automatic m_comp(input logic [31:0] v);
    if (op.size() < D) op.push_back(v); else m_ist[3] = 1;
    p_opush = 1; p_odata = v; tick();
  endtask
  task automatic m_alloc(string tag);
    logic [31:0] d, e;
    e = fl.size() ? fl.pop_front() : 32'hFFFF_FFFF;
    hrd(6'd16, d); chk(tag, d, e);
  endtask
  task automatic m_collect(string tag);
    logic [31:0] d, e;
    e = op.size() ? op.pop_front() : 32'hFFFF_FFFF;
    hrd(6'd17, d); chk(tag, d, e);
  endtask
  task automatic m_ppop(string tag);
    chk({tag, " valid"}, {31'd0, p_ivalid}, {31'd0, ip.size() != 0});
    if (ip.size()) begin
      chk({tag, " data"}, p_idata, ip.pop_front());
      p_ipop = 1; tick();
    end
  endtask
  task automatic m_status(string tag);
    logic [31:0] d;
    hrd(6'd9, d);  chk({tag, " istat"}, d, {27'd0, exp_ist()});
    hrd(6'd12, d); chk({tag, " ostat"}, d, {27'd0, exp_ost()});
    chk({tag, " host_irq"}, {31'd0, host_irq}, {31'd0, |(exp_ost() & ~m_omask)});
    chk({tag, " p_irq"}, {31'd0, p_irq}, {31'd0, |(exp_ist() & ~m_imask)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    m_status("R1 reset");
    hrd(6'd4, d); chk("R1 imsg0", d, 0);
    hrd(6'd13, d); chk("R1 omask", d, 0);
    m_alloc("R1 R2 empty free list");
    m_collect("R1 R5 empty outbound");

    // R2 R6 seeding and allocation order
    m_seed(32'h100); m_seed(32'h140); m_seed(32'h180);
    m_alloc("R2 alloc 1"); m_alloc("R2 alloc 2"); m_alloc("R2 alloc 3");
    m_alloc("R2 alloc empty");

    // R6 simultaneous host return and seed
    h_wr = 1; h_woff = 6'd17; h_wdata = 32'h200; p_fpush = 1; p_fdata = 32'h240;
    fl.push_back(32'h200); fl.push_back(32'h240);
    @(posedge clk); @(negedge clk); h_wr = 0; p_fpush = 0;
    m_alloc("R6 host first"); m_alloc("R6 seed second");

    // R4 host-owned handle discarded
    m_ret(32'h300); m_ret(32'h9000_0012); m_ret(32'h1000_0000);
    m_alloc("R4 device handle"); m_alloc("R4 host handle dropped");

    // R3 R10 inbound post and level bit
    m_post(32'h400); m_post(32'h8000_1234);
    m_status("R10 inbound level");
    hwr(6'd9, 32'h1F); m_status("R10 level not cleared");
    m_ppop("R3 pop 1"); m_ppop("R3 pop 2"); m_ppop("R3 empty");

    // R7 messages in
    hwr(6'd4, 32'd2); m_ist[0] = 1; chk("R7 imsg0", p_imsg0, 2);
    hwr(6'd5, 32'd5); m_ist[1] = 1; chk("R7 imsg1", p_imsg1, 5);
    m_status("R7 status");
    p_iclr = 4'b0011; tick(); m_ist[1:0] = 0; m_status("R10 proc clear");

    // R8 R11 outbound messages and masking
    p_omsg_wr = 2'b01; p_omsg_data = 32'd2; tick(); m_ost[0] = 1;
    hrd(6'd6, d); chk("R8 omsg0", d, 2);
    hwr(6'd6, 32'hDEAD); hrd(6'd6, d); chk("R8 host write ignored", d, 2);
    m_status("R8 R11 irq");
    hwr(6'd13, 32'h1); m_omask = 5'h1; m_status("R11 masked");
    hwr(6'd12, 32'h1); m_ost[0] = 0; m_status("R10 W1C");
    hwr(6'd13, 32'h0); m_omask = 0;

    // R9 doorbell
    hwr(6'd8, 32'h5); hwr(6'd8, 32'h30); m_ist[2] = 1;
    chk("R9 doorbell or", p_dbell, 32'h35);
    p_dbclr = 32'h4; tick(); chk("R9 doorbell clear", p_dbell, 32'h31);
    p_oraise = 2'b11; tick(); m_ost[2] = 1; m_ost[3] = 1;
    m_status("R9 raise");
    hwr(6'd12, 32'h1F); hwr(6'd9, 32'hF); m_ost = 0; m_ist = 0;
    m_status("R10 all clear");

    // R3 R12 overflow
    for (int i = 0; i < D + 1; i++) m_post(32'h1000 + i * 32);
    m_status("R3 post overflow");
    for (int i = 0; i < D; i++) m_ppop("R3 drain");
    hwr(6'd9, 32'h8); m_ist[3] = 0;
    for (int i = 0; i < D + 1; i++) m_comp(32'h2000 + i * 32);
    m_status("R12 completion overflow");
    for (int i = 0; i < D + 1; i++) m_collect("R5 drain");
    hwr(6'd9, 32'h8); m_ist[3] = 0;

    // randomized mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] v;
      v = $urandom & 32'h0FFF_FFE0;
      case ($urandom % 9)
        0: m_post(($urandom % 2) ? (v | 32'h8000_0000) : v);
        1: m_ppop("R3 random pop");
        2: m_comp(v);
        3: m_collect("R5 random collect");
        4: m_ret(($urandom % 3 == 0) ? (v | 32'hA000_0000) : v);
        5: m_alloc("R2 random alloc");
        6: m_seed(v);
        7: begin hwr(6'd9, 32'hF); m_ist = 0; end
        default: m_status("R11 random status");
      endcase
    end
    m_status("R10 final");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule